// File: doc/BRIEF.md
# Window Watchdog With Reset Generator

This block supervises a microcontroller through a windowed timing check. After each restart it first runs a closed interval, in which the controller must stay quiet. An open interval follows, in which the controller must produce a rising edge on the trigger input. All timing is counted in ticks of a clock-enable strobe. That strobe comes from an adjustable oscillator outside the block, so the interval lengths in real time scale with the oscillator period.

A trigger edge inside the open interval is a valid service, and the closed interval starts again at once. A trigger edge inside the closed interval is a fault. The open interval running out with no trigger edge is also a fault. Either fault drives the active-low reset output for a short pulse. When that pulse releases, a new closed interval begins. At power-up, and on leaving sleep, the block drives a longer reset pulse instead. While the sleep input is high, the watchdog stops, its count is cleared and the reset output is held low. The trigger input passes through a synchronizer before its edge is detected.

Top module: `win_wdog`

## Requirements
- R1: While `rst_ni` is low, `rst_out_no` is 0. After `rst_ni` rises, `rst_out_no` stays 0 for exactly LONG_RST_TICKS ticks and goes to 1 one clock after the last of those ticks.
- R2: The closed interval lasts CLOSED_TICKS ticks from each restart. A rising trigger edge inside it drives `rst_out_no` to 0 and starts a short reset.
- R3: The open interval lasts OPEN_TICKS ticks after the closed interval. If it ends with no rising trigger edge, `rst_out_no` goes to 0 and a short reset starts.
- R4: A rising trigger edge at any point in the open interval, including its last tick period, keeps `rst_out_no` at 1 and restarts the closed interval from a count of zero.
- R5: A short reset holds `rst_out_no` at 0 for exactly SHORT_RST_TICKS ticks. A closed interval then begins with `rst_out_no` at 1.
- R6: Only a 0-to-1 transition of `trig_i` counts as a trigger. Holding `trig_i` high, a falling transition, and edges that arrive during a reset pulse or during sleep all have no effect.
- R7: While `sleep_i` is high, `rst_out_no` is 0 and the interval count is held at zero. After `sleep_i` falls, a long reset of LONG_RST_TICKS ticks runs before the window starts.
- R8: Interval and reset counts advance only on clock cycles with `tick_i` high. A rising edge on `trig_i` takes effect on the third rising clock edge after the edge is first sampled, since it passes SYNC_STAGES=2 synchronizer stages and one edge register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| tick_i | input | 1 | Timebase strobe, one clock wide per oscillator period |
| sleep_i | input | 1 | High stops and clears the watchdog |
| trig_i | input | 1 | Service trigger from the supervised controller (asynchronous) |
| rst_out_no | output | 1 | Active-low reset to the supervised controller |

## Verification
The assertions check, on every cycle, the single-step rules:
- an early edge leads to a short reset;
- a valid edge restarts the closed interval at zero;
- the open interval expiring leads to a short reset;
- counts stay frozen without a tick;
- edges are ignored during reset pulses;
- sleep forces the output low;
- every release lands at the start of a closed interval.

Exact pulse and interval lengths, measured in ticks, can only be shown by the bench's scenarios. So can the boundary placements of trigger edges, the held-high trigger, and the long reset after sleep. The bench runs these against a tick-level model driven by directed and random stimulus.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_LONG_RST  = 2'd0,
        WD_SHORT_RST = 2'd1,
        WD_CLOSED    = 2'd2,
        WD_OPEN      = 2'd3
    } wd_state_e;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdog_trig_edge.sv
module wdog_trig_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic rise_o
);
    localparam int unsigned SW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SW-1:0] sh;
    } edge_reg_t;

    edge_reg_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.sh = {r_q.sh[SW-2:0], trig_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign rise_o = r_q.sh[SW-2] & ~r_q.sh[SW-1];

    // R6: a detected rise lasts one clock only
    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/wdog_window_fsm.sv
module wdog_window_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned CLOSED_TICKS    = 24,
    parameter int unsigned OPEN_TICKS      = 19,
    parameter int unsigned LONG_RST_TICKS  = 64,
    parameter int unsigned SHORT_RST_TICKS = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic rise_i,
    input  logic sleep_i,
    output logic rst_out_no
);
    localparam int unsigned MAXT = max_of4(CLOSED_TICKS, OPEN_TICKS,
                                           LONG_RST_TICKS, SHORT_RST_TICKS);
    localparam int unsigned CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] LIM_CLOSED = CW'(CLOSED_TICKS - 1);
    localparam logic [CW-1:0] LIM_OPEN   = CW'(OPEN_TICKS - 1);
    localparam logic [CW-1:0] LIM_LONG   = CW'(LONG_RST_TICKS - 1);
    localparam logic [CW-1:0] LIM_SHORT  = CW'(SHORT_RST_TICKS - 1);

    typedef struct packed {
        wd_state_e     st;
        logic [CW-1:0] cnt;
        logic          out_n;
    } fsm_reg_t;

    fsm_reg_t r_d, r_q;
    logic [CW-1:0] lim;
    logic          last_tick;

    always_comb begin
        unique case (r_q.st)
            WD_LONG_RST:  lim = LIM_LONG;
            WD_SHORT_RST: lim = LIM_SHORT;
            WD_CLOSED:    lim = LIM_CLOSED;
            default:      lim = LIM_OPEN;
        endcase
        last_tick = tick_i && (r_q.cnt == lim);

        r_d = r_q;
        if (sleep_i) begin
            r_d.st  = WD_LONG_RST;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                WD_LONG_RST, WD_SHORT_RST: begin
                    if (last_tick) begin
                        r_d.st  = WD_CLOSED;
                        r_d.cnt = '0;
                    end else if (tick_i) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                WD_CLOSED: begin
                    if (rise_i) begin
                        r_d.st  = WD_SHORT_RST;
                        r_d.cnt = '0;
                    end else if (last_tick) begin
                        r_d.st  = WD_OPEN;
                        r_d.cnt = '0;
                    end else if (tick_i) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (rise_i) begin
                        r_d.st  = WD_CLOSED;
                        r_d.cnt = '0;
                    end else if (last_tick) begin
                        r_d.st  = WD_SHORT_RST;
                        r_d.cnt = '0;
                    end else if (tick_i) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            endcase
        end
        r_d.out_n = (r_d.st == WD_CLOSED) || (r_d.st == WD_OPEN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st    <= WD_LONG_RST;
            r_q.cnt   <= '0;
            r_q.out_n <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rst_out_no = r_q.out_n;

    // R2: early trigger inside the closed interval faults
    a_r2_early_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == WD_CLOSED && rise_i && !sleep_i)
        |=> (r_q.st == WD_SHORT_RST && !rst_out_no));

    // R4: trigger in the open interval restarts the closed interval
    a_r4_valid_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == WD_OPEN && rise_i && !sleep_i)
        |=> (r_q.st == WD_CLOSED && r_q.cnt == '0 && rst_out_no));

    // R3: open interval expiring without a trigger faults
    a_r3_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == WD_OPEN && tick_i && !rise_i && !sleep_i && r_q.cnt == LIM_OPEN)
        |=> (r_q.st == WD_SHORT_RST && !rst_out_no));

    // R5: each release starts a fresh closed interval
    a_r5_release_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_out_no) |-> (r_q.st == WD_CLOSED && r_q.cnt == '0));

    // R7: sleep holds the reset low and clears the count
    a_r7_sleep_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |=> (!rst_out_no && r_q.cnt == '0));

    // R8: no tick, no edge, no sleep: the count is frozen
    a_r8_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !rise_i && !sleep_i) |=> $stable(r_q.cnt));

    // R6: edges during a reset pulse change nothing
    a_r6_ignore_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((r_q.st == WD_LONG_RST || r_q.st == WD_SHORT_RST) && rise_i && !tick_i && !sleep_i)
        |=> ($stable(r_q.st) && $stable(r_q.cnt)));

endmodule

// File: rtl/win_wdog.sv
module win_wdog #(
    parameter int unsigned CLOSED_TICKS    = 24,
    parameter int unsigned OPEN_TICKS      = 19,
    parameter int unsigned LONG_RST_TICKS  = 64,
    parameter int unsigned SHORT_RST_TICKS = 8,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic sleep_i,
    input  logic trig_i,
    output logic rst_out_no
);
    logic rise;

    wdog_trig_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (trig_i),
        .rise_o (rise)
    );

    wdog_window_fsm #(
        .CLOSED_TICKS    (CLOSED_TICKS),
        .OPEN_TICKS      (OPEN_TICKS),
        .LONG_RST_TICKS  (LONG_RST_TICKS),
        .SHORT_RST_TICKS (SHORT_RST_TICKS)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .rise_i     (rise),
        .sleep_i    (sleep_i),
        .rst_out_no (rst_out_no)
    );

endmodule

// File: tb/win_wdog_bench.sv
`timescale 1ns/1ps
module win_wdog_bench;
    localparam int CL = 5;
    localparam int OP = 4;
    localparam int LG = 7;
    localparam int SH = 3;

    logic clk = 1'b0;
    logic rst_ni, tick_i, sleep_i, trig_i;
    logic rst_out_no;

    always #2.5 clk = ~clk;

    win_wdog #(
        .CLOSED_TICKS (CL), .OPEN_TICKS (OP),
        .LONG_RST_TICKS (LG), .SHORT_RST_TICKS (SH), .SYNC_STAGES (2)
    ) u_win_wdog (
        .clk_i (clk), .rst_ni (rst_ni), .tick_i (tick_i),
        .sleep_i (sleep_i), .trig_i (trig_i), .rst_out_no (rst_out_no)
    );

    // tick-level model: 0 long reset, 1 short reset, 2 closed, 3 open
    int    m_st, m_cnt;
    bit    m_sleep;
    string m_tag;
    int    n_chk, n_fail;
    bit    done;

    function automatic int m_len(int s);
        case (s)
            0: return LG;
            1: return SH;
            2: return CL;
            default: return OP;
        endcase
    endfunction

    function automatic bit m_exp();
        return (m_st == 2 || m_st == 3);
    endfunction

    function automatic void m_tick();
        if (m_sleep) begin m_tag = "R7"; return; end
        case (m_st)
            0: m_tag = "R1";
            1: m_tag = "R5";
            2: m_tag = "R2";
            default: m_tag = "R3";
        endcase
        if (m_cnt == m_len(m_st) - 1) begin
            m_cnt = 0;
            case (m_st)
                0, 1: m_st = 2;
                2: m_st = 3;
                default: m_st = 1;
            endcase
        end else begin
            m_cnt++;
        end
    endfunction

    function automatic void m_edge();
        if (m_sleep) begin m_tag = "R7"; return; end
        case (m_st)
            2: begin m_st = 1; m_cnt = 0; m_tag = "R2"; end
            3: begin m_st = 2; m_cnt = 0; m_tag = "R4"; end
            default: m_tag = "R6";
        endcase
    endfunction

    task automatic chk(string tag);
        n_chk++;
        if (rst_out_no !== m_exp()) begin
            n_fail++;
            $display("FAIL %s: rst_out_no=%0b expected %0b (state %0d cnt %0d)",
                     tag, rst_out_no, m_exp(), m_st, m_cnt);
        end
    endtask

    // one timebase period of 10 clocks: optional trigger, then a tick
    task automatic step(bit do_trig, bit hold);
        bit pend;
        pend = do_trig && !trig_i;
        if (do_trig) trig_i = 1'b1;
        repeat (4) @(negedge clk);
        if (pend) m_edge();
        else if (do_trig) m_tag = "R6";
        else m_tag = "R8";
        chk(m_tag);
        if (!hold) trig_i = 1'b0;
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        m_tick();
        repeat (2) @(negedge clk);
        chk(m_tag);
        repeat (2) @(negedge clk);
    endtask

    task automatic advance(int st, int cnt);
        int g;
        g = 0;
        while (!(m_st == st && m_cnt == cnt) && g < 60) begin
            step(1'b0, 1'b0);
            g++;
        end
    endtask

    task automatic set_sleep(bit v);
        sleep_i = v;
        repeat (2) @(negedge clk);
        m_sleep = v;
        if (v) begin m_st = 0; m_cnt = 0; end
        m_tag = "R7";
        chk("R7");
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5813));
        n_chk = 0; n_fail = 0; done = 1'b0;
        rst_ni = 1'b0; tick_i = 1'b0; sleep_i = 1'b0; trig_i = 1'b0;
        m_st = 0; m_cnt = 0; m_sleep = 1'b0; m_tag = "R1";
        repeat (4) @(negedge clk);
        chk("R1");                                  // R1 reset state
        rst_ni = 1'b1;
        repeat (2) @(negedge clk);

        // R1 long reset, then R3 timeout and R5 short reset with no service
        advance(1, 0);
        advance(2, 0);
        // R2: edge in the last closed tick period
        advance(2, CL - 1);
        step(1'b1, 1'b0);
        // R4: edge in the first open tick period
        advance(3, 0);
        step(1'b1, 1'b0);
        // R4: edge in the last open tick period
        advance(3, OP - 1);
        step(1'b1, 1'b0);
        // R6: trigger held high gives a single edge, the fall gives none
        advance(3, 1);
        step(1'b1, 1'b1);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        // R6: edge during a short reset
        advance(1, 1);
        step(1'b1, 1'b0);
        // R7: sleep, triggers while asleep, then a long reset on wake
        advance(3, 1);
        set_sleep(1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        set_sleep(1'b0);
        advance(2, 0);

        // constrained random traffic
        for (int i = 0; i < 600; i++) begin
            int r;
            bit t;
            r = $urandom_range(99);
            if (m_st == 3)      t = (r < 45);
            else if (m_st == 2) t = (r < 8);
            else                t = (r < 15);
            if ($urandom_range(59) == 0) set_sleep(!sleep_i);
            step(t, $urandom_range(9) == 0);
        end
        if (sleep_i) set_sleep(1'b0);
        advance(2, 0);
        finish_run();
    end

endmodule